// File: doc/BRIEF.md
# LIN Bus Master Frame Controller

This block runs complete frames as the only master on a single-wire LIN bus. When the host pulses `start`, it drives the frame header on `tx`. The header is a dominant break of a parameterised number of bit times (13 by default), one recessive delimiter bit, the sync character and the protected identifier. All characters are 8N1 and sent least significant bit first. A bit-rate divider, fed by an accurate clock, sets every bit to `CLK_DIV` clock cycles.

The `is_request` flag then picks one of two frame types. For a command frame the controller keeps driving the bus. It takes the data bytes from a valid/ready write stream and closes the frame with a checksum character. For a request frame it releases the bus after the identifier. It then receives the slave's data bytes and checksum on `rx`, forwards each data byte on a read stream and verifies the checksum. While driving, every bit read back on `rx` is compared with the bit driven. A mismatch aborts the frame.

Stream rules: `wr_ready` is high only while the controller waits for the next command byte, and a byte moves on a clock edge where `wr_valid` and `wr_ready` are both high. The host may hold off a byte as long as it likes; the line stays recessive meanwhile. The read stream is valid-only: a running response cannot be paused, so `rd_valid` is a one-cycle strobe and the sink must take `rd_data` in that cycle.

Top module: `lin_master_ctrl`

## Requirements
- R1: After reset, and whenever no frame is running, `tx` is 1 and `busy`, `done`, `wr_ready` and `rd_valid` are 0.
- R2: On the clock edge that accepts `start` while idle, `tx` goes to 0. It stays 0 for exactly BREAK_BITS*CLK_DIV cycles and is then 1 for exactly CLK_DIV cycles before the sync start bit.
- R3: The sync character is 0x55 and the next character is the protected identifier: bits 5..0 hold the ID, bit 6 is ID0^ID1^ID2^ID4 and bit 7 is the inverse of ID1^ID3^ID4^ID5. Each character is one start bit of 0, eight data bits LSB first and one stop bit of 1, each CLK_DIV cycles long.
- R4: A command frame carries `dlen_m1`+1 data bytes (1 to 8), sent in write-stream order and followed by the checksum. If each byte is offered before it is asked for, `done` is set (14+10*(3+n))*CLK_DIV+n cycles after the start edge.
- R5: `wr_ready` is high only between bytes of a command frame, and `tx` is 1 while it is high. Withholding a byte for S extra cycles delays `done` by exactly S cycles.
- R6: The checksum is the bitwise inverse of the 8-bit sum of the data bytes with each carry out added back in. When `enhanced` is 1 at start, the protected identifier is included as the first addend.
- R7: In a request frame, `tx` stays 1 from the identifier's stop bit until `done`. Each received data byte appears on `rd_data` with a one-cycle `rd_valid`, in bus order. The checksum byte is not forwarded.
- R8: A request frame whose received checksum differs from the one computed over its received bytes ends with error code 3.
- R9: If `rx` differs from the driven level at the middle of any driven bit (break, delimiter or character), the frame ends at once with error code 1, and `tx` returns to 1.
- R10: If a request frame has not received all of its bytes within TIMEOUT_BITS bit times of the bus release, it ends with error code 2. With a silent slave, `done` comes (34+TIMEOUT_BITS)*CLK_DIV cycles after the start edge.
- R11: A received character whose stop bit reads 0 ends the frame with error code 4.
- R12: A `start` pulse while `busy` is 1 is ignored, and the frame in progress keeps its identifier.
- R13: `done` is a one-cycle pulse with `busy` already 0. `err_code` (0 none, 1 bit error, 2 timeout, 3 checksum, 4 framing) and `err` = (`err_code` != 0) are set with `done` and held until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, crystal-derived |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame; taken only when idle |
| frame_id | input | 6 | Frame identifier, sampled with start |
| is_request | input | 1 | 1 = slave answers, 0 = master sends data |
| dlen_m1 | input | 3 | Number of data bytes minus one |
| enhanced | input | 1 | Include protected identifier in checksum |
| wr_valid | input | 1 | Write stream: byte offered |
| wr_ready | output | 1 | Write stream: byte wanted |
| wr_data | input | 8 | Write stream: command data byte |
| rd_valid | output | 1 | Read stream: one-cycle byte strobe |
| rd_data | output | 8 | Read stream: received data byte |
| tx | output | 1 | Bus drive, 1 = recessive |
| rx | input | 1 | Bus read-back |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished, one cycle |
| err | output | 1 | Last frame ended in error |
| err_code | output | 3 | Reason for the last frame's end |

## Verification
Every result has a fixed time from a known edge. The break is low for BREAK_BITS*CLK_DIV cycles and the delimiter is high for CLK_DIV. A command frame's `done` is due (14+10*(3+n))*CLK_DIV+n cycles after the start edge, plus any stall cycles on the write stream. A silent request frame ends (34+TIMEOUT_BITS)*CLK_DIV cycles after the start edge. The bench counts clock edges from the accepting edge to the first `done` and compares that count with these formulas. It decodes `tx` at the middle of each bit, counted from the falling edge of the start bit. Inputs are driven and outputs sampled on the falling clock edge, so each sample falls half a cycle after the register that produced it.

// File: rtl/lin_master_pkg.sv
package lin_master_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_BIT      = 3'd1,
    ERR_TIMEOUT  = 3'd2,
    ERR_CHECKSUM = 3'd3,
    ERR_FRAMING  = 3'd4
  } lin_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_DELIM,
    ST_TXCHAR,
    ST_WAITDATA,
    ST_RXWAIT,
    ST_RXCHAR
  } lin_state_e;

  typedef enum logic [1:0] {
    CH_SYNC,
    CH_PID,
    CH_DATA,
    CH_CSUM
  } lin_char_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;

  // identifier with its two parity bits on top
  function automatic logic [7:0] lin_pid(input logic [5:0] id);
    logic p_lo;
    logic p_hi;
    p_lo = id[0] ^ id[1] ^ id[2] ^ id[4];
    p_hi = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p_hi, p_lo, id};
  endfunction

endpackage

// File: rtl/lin_baud_gen.sv
module lin_baud_gen #(
  parameter int CLK_DIV = 2604
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic bit_mid,
  output logic bit_last
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 2;
  localparam logic [CW-1:0] MID_CNT  = CW'(CLK_DIV / 2);
  localparam logic [CW-1:0] LAST_CNT = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign bit_mid  = (cnt_q == MID_CNT);
  assign bit_last = (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart || bit_last) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/lin_chk_acc.sv
module lin_chk_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [7:0] init_val,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] chk
);
  logic [7:0] acc_q;
  logic [8:0] sum9;

  assign sum9 = {1'b0, acc_q} + {1'b0, din};
  assign chk  = ~acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= init_val;
    else if (add)   acc_q <= sum9[7:0] + {7'd0, sum9[8]};
  end
endmodule

// File: rtl/lin_master_ctrl.sv
module lin_master_ctrl
  import lin_master_pkg::*;
#(
  parameter int CLK_DIV      = 2604,
  parameter int BREAK_BITS   = 13,
  parameter int TIMEOUT_BITS = 140
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [5:0] frame_id,
  input  logic       is_request,
  input  logic [2:0] dlen_m1,
  input  logic       enhanced,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       tx,
  input  logic       rx,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [2:0] err_code
);
  localparam int BCW = $clog2(((BREAK_BITS > 10) ? BREAK_BITS : 10) + 1);
  localparam int TCW = $clog2(TIMEOUT_BITS + 1);
  localparam logic [BCW-1:0] BRK_LAST = BCW'(BREAK_BITS - 1);
  localparam logic [BCW-1:0] STOP_IDX = BCW'(9);
  localparam logic [TCW-1:0] TMO_LAST = TCW'(TIMEOUT_BITS - 1);

  lin_state_e     state_q;
  lin_char_e      chr_q;
  lin_err_e       code_q;
  logic [9:0]     sh_q;
  logic           tx_q;
  logic [BCW-1:0] bitcnt_q;
  logic [2:0]     idx_q;
  logic [3:0]     ridx_q;
  logic [2:0]     nm1_q;
  logic [7:0]     pid_q;
  logic           req_q;
  logic [TCW-1:0] tmo_q;
  logic [7:0]     rxsh_q;
  logic           done_q;
  logic           rd_valid_q;
  logic [7:0]     rd_data_q;

  logic       rx_s;
  logic       bit_mid;
  logic       bit_last;
  logic       start_go;
  logic       load_data;
  logic       resp_phase;
  logic       tmo_hit;
  logic       rx_detect;
  logic       rx_stop;
  logic       data_left;
  logic       baud_restart;
  logic       acc_add;
  logic [7:0] acc_din;
  logic [7:0] acc_init;
  logic [7:0] chk_val;

  lin_rx_sync #(.STAGES(2)) rx_sync_i (
    .clk (clk), .rst_n (rst_n), .din (rx), .dout (rx_s)
  );

  lin_baud_gen #(.CLK_DIV(CLK_DIV)) baud_i (
    .clk (clk), .rst_n (rst_n), .restart (baud_restart),
    .bit_mid (bit_mid), .bit_last (bit_last)
  );

  lin_chk_acc chk_i (
    .clk (clk), .rst_n (rst_n), .clear (start_go), .init_val (acc_init),
    .add (acc_add), .din (acc_din), .chk (chk_val)
  );

  always_comb begin
    start_go     = (state_q == ST_IDLE) && start;
    load_data    = (state_q == ST_WAITDATA) && wr_valid;
    resp_phase   = (state_q == ST_RXWAIT) || (state_q == ST_RXCHAR);
    tmo_hit      = resp_phase && bit_last && (tmo_q == TMO_LAST);
    rx_detect    = (state_q == ST_RXWAIT) && !rx_s && !tmo_hit;
    rx_stop      = (state_q == ST_RXCHAR) && bit_mid && (bitcnt_q == STOP_IDX) && rx_s;
    data_left    = (ridx_q <= {1'b0, nm1_q});
    baud_restart = start_go || load_data || rx_detect;
    acc_add      = load_data || (rx_stop && data_left);
    acc_din      = load_data ? wr_data : rxsh_q;
    acc_init     = enhanced ? lin_pid(frame_id) : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      chr_q      <= CH_SYNC;
      code_q     <= ERR_NONE;
      sh_q       <= '1;
      tx_q       <= 1'b1;
      bitcnt_q   <= '0;
      idx_q      <= '0;
      ridx_q     <= '0;
      nm1_q      <= '0;
      pid_q      <= '0;
      req_q      <= 1'b0;
      tmo_q      <= '0;
      rxsh_q     <= '0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          tx_q <= 1'b1;
          if (start_go) begin
            state_q  <= ST_BREAK;
            code_q   <= ERR_NONE;
            tx_q     <= 1'b0;
            bitcnt_q <= '0;
            pid_q    <= lin_pid(frame_id);
            req_q    <= is_request;
            nm1_q    <= dlen_m1;
          end
        end
        ST_BREAK: begin
          if (bit_mid && rx_s) begin
            state_q <= ST_IDLE; tx_q <= 1'b1; done_q <= 1'b1; code_q <= ERR_BIT;
          end else if (bit_last) begin
            if (bitcnt_q == BRK_LAST) begin
              state_q  <= ST_DELIM;
              tx_q     <= 1'b1;
              bitcnt_q <= '0;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_DELIM: begin
          if (bit_mid && !rx_s) begin
            state_q <= ST_IDLE; tx_q <= 1'b1; done_q <= 1'b1; code_q <= ERR_BIT;
          end else if (bit_last) begin
            state_q  <= ST_TXCHAR;
            chr_q    <= CH_SYNC;
            sh_q     <= {1'b1, SYNC_BYTE, 1'b0};
            tx_q     <= 1'b0;
            bitcnt_q <= '0;
          end
        end
        ST_TXCHAR: begin
          if (bit_mid && (rx_s != tx_q)) begin
            state_q <= ST_IDLE; tx_q <= 1'b1; done_q <= 1'b1; code_q <= ERR_BIT;
          end else if (bit_last) begin
            if (bitcnt_q == STOP_IDX) begin
              bitcnt_q <= '0;
              unique case (chr_q)
                CH_SYNC: begin
                  chr_q <= CH_PID;
                  sh_q  <= {1'b1, pid_q, 1'b0};
                  tx_q  <= 1'b0;
                end
                CH_PID: begin
                  tx_q <= 1'b1;
                  if (req_q) begin
                    state_q <= ST_RXWAIT;
                    tmo_q   <= '0;
                    ridx_q  <= '0;
                  end else begin
                    state_q <= ST_WAITDATA;
                    chr_q   <= CH_DATA;
                    idx_q   <= '0;
                  end
                end
                CH_DATA: begin
                  if (idx_q == nm1_q) begin
                    chr_q <= CH_CSUM;
                    sh_q  <= {1'b1, chk_val, 1'b0};
                    tx_q  <= 1'b0;
                  end else begin
                    idx_q   <= idx_q + 1'b1;
                    state_q <= ST_WAITDATA;
                    tx_q    <= 1'b1;
                  end
                end
                default: begin
                  state_q <= ST_IDLE; tx_q <= 1'b1; done_q <= 1'b1; code_q <= ERR_NONE;
                end
              endcase
            end else begin
              sh_q     <= {1'b1, sh_q[9:1]};
              tx_q     <= sh_q[1];
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_WAITDATA: begin
          tx_q <= 1'b1;
          if (load_data) begin
            state_q  <= ST_TXCHAR;
            sh_q     <= {1'b1, wr_data, 1'b0};
            tx_q     <= 1'b0;
            bitcnt_q <= '0;
          end
        end
        ST_RXWAIT: begin
          tx_q <= 1'b1;
          if (tmo_hit) begin
            state_q <= ST_IDLE; done_q <= 1'b1; code_q <= ERR_TIMEOUT;
          end else begin
            if (bit_last) tmo_q <= tmo_q + 1'b1;
            if (rx_detect) begin
              state_q  <= ST_RXCHAR;
              bitcnt_q <= '0;
            end
          end
        end
        ST_RXCHAR: begin
          tx_q <= 1'b1;
          if (tmo_hit) begin
            state_q <= ST_IDLE; done_q <= 1'b1; code_q <= ERR_TIMEOUT;
          end else if (bit_last) begin
            tmo_q    <= tmo_q + 1'b1;
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (bit_mid) begin
            if (bitcnt_q == '0) begin
              if (rx_s) state_q <= ST_RXWAIT;
            end else if (bitcnt_q != STOP_IDX) begin
              rxsh_q <= {rx_s, rxsh_q[7:1]};
            end else if (!rx_s) begin
              state_q <= ST_IDLE; done_q <= 1'b1; code_q <= ERR_FRAMING;
            end else if (data_left) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= rxsh_q;
              ridx_q     <= ridx_q + 1'b1;
              state_q    <= ST_RXWAIT;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              code_q  <= (rxsh_q == chk_val) ? ERR_NONE : ERR_CHECKSUM;
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
          tx_q    <= 1'b1;
        end
      endcase
    end
  end

  assign tx       = tx_q;
  assign busy     = (state_q != ST_IDLE);
  assign wr_ready = (state_q == ST_WAITDATA);
  assign done     = done_q;
  assign err_code = code_q;
  assign err      = (code_q != ERR_NONE);
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/lin_master_ctrl_chk.sv
module lin_master_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       tx,
  input logic       done,
  input logic       err,
  input logic [2:0] err_code,
  input logic       wr_ready,
  input logic       rd_valid
);
  // R1: line recessive whenever no frame runs
  p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R2: an accepted start pulls the line low on the next edge
  p_start_break_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !tx));

  // R5: write stream asked for only between bytes, with the line recessive
  p_ready_recessive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && tx && !rd_valid));

  // R7: received bytes only show up while the bus is released
  p_rd_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && tx && !wr_ready));

  // R13: done is a single cycle and comes with the block idle
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && tx));

  p_err_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_code_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_code));
endmodule

bind lin_master_ctrl lin_master_ctrl_chk chk_bind_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .tx       (tx),
  .done     (done),
  .err      (err),
  .err_code (err_code),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid)
);

// File: tb/lin_master_ctrl_tb_top.sv
module lin_master_ctrl_tb_top;
  localparam int DIV = 16;
  localparam int BRK = 13;
  localparam int TMO = 110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] frame_id = '0;
  logic       is_request = 1'b0;
  logic [2:0] dlen_m1 = '0;
  logic       enhanced = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       tx;
  logic       rx;
  logic       busy;
  logic       done;
  logic       err;
  logic [2:0] err_code;
  logic       slave_q = 1'b1;
  logic       stuck = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_start = 0;
  int t_done = 0;
  logic [7:0] rcv [0:15];
  int rcv_n = 0;

  assign rx = tx & slave_q & ~stuck;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rd_valid) begin
    if (rcv_n < 16) rcv[rcv_n] = rd_data;
    rcv_n = rcv_n + 1;
  end

  lin_master_ctrl #(.CLK_DIV(DIV), .BREAK_BITS(BRK), .TIMEOUT_BITS(TMO)) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .frame_id (frame_id),
    .is_request (is_request), .dlen_m1 (dlen_m1), .enhanced (enhanced),
    .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_data (wr_data),
    .rd_valid (rd_valid), .rd_data (rd_data), .tx (tx), .rx (rx),
    .busy (busy), .done (done), .err (err), .err_code (err_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pid_of(input logic [5:0] id);
    logic [7:0] p;
    p[5:0] = id;
    p[6] = id[0] ^ id[1] ^ id[2] ^ id[4];
    p[7] = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return p;
  endfunction

  function automatic logic [7:0] cmd_byte(input int id, input int k);
    return 8'((id * 37 + k * 91 + 5) & 255);
  endfunction

  function automatic logic [7:0] resp_byte(input int id, input int k);
    return 8'((id * 53 + k * 29 + 11) & 255);
  endfunction

  function automatic logic [7:0] csum_of(input int id, input int n, input bit enh, input bit resp);
    int s;
    s = enh ? int'(pid_of(6'(id))) : 0;
    for (int k = 0; k < n; k++) begin
      s += resp ? int'(resp_byte(id, k)) : int'(cmd_byte(id, k));
      if (s > 255) s -= 255;
    end
    return 8'(~s);
  endfunction

  task automatic send_start(input int id, input bit req, input int dlm1, input bit enh);
    @(negedge clk);
    frame_id = 6'(id); is_request = req; dlen_m1 = 3'(dlm1); enhanced = enh; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_start = cyc;
  endtask

  task automatic get_char(output logic [7:0] b, output bit ok);
    logic s0;
    logic s9;
    while (tx) @(negedge clk);
    repeat (DIV / 2) @(negedge clk);
    s0 = tx;
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = tx;
    end
    repeat (DIV) @(negedge clk);
    s9 = tx;
    ok = (s0 == 1'b0) && (s9 == 1'b1);
  endtask

  task automatic check_header(input int id);
    int lo;
    int hi;
    logic [7:0] b;
    bit ok;
    lo = 0; hi = 0;
    while (!tx) begin lo++; @(negedge clk); end
    while (tx)  begin hi++; @(negedge clk); end
    chk(lo == BRK * DIV, "R2 break low cycles", lo, BRK * DIV);
    chk(hi == DIV, "R2 delimiter cycles", hi, DIV);
    get_char(b, ok);
    chk(ok && b == 8'h55, "R3 sync char", int'(b), 8'h55);
    get_char(b, ok);
    chk(ok && b == pid_of(6'(id)), "R3 protected id", int'(b), int'(pid_of(6'(id))));
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    t_done = cyc;
  endtask

  task automatic run_cmd(input int id, input int dlm1, input bit enh, input int stall_idx,
                         input int stall, input bit glitch);
    int n;
    n = dlm1 + 1;
    wr_valid = (stall_idx != 0);
    wr_data = cmd_byte(id, 0);
    send_start(id, 1'b0, dlm1, enh);
    fork
      begin : feed
        for (int k = 0; k < n; k++) begin
          if (k == stall_idx) begin
            while (!wr_ready) @(negedge clk);
            repeat (stall) @(negedge clk);
            wr_data = cmd_byte(id, k);
            wr_valid = 1'b1;
          end
          while (!wr_ready) @(negedge clk);
          @(posedge clk); #1;
          if (k + 1 == stall_idx) wr_valid = 1'b0;
          else wr_data = cmd_byte(id, k + 1);
        end
        wr_valid = 1'b0;
      end
      begin : decode
        logic [7:0] b;
        bit ok;
        check_header(id);
        for (int k = 0; k < n; k++) begin
          get_char(b, ok);
          chk(ok && b == cmd_byte(id, k), "R4 data char", int'(b), int'(cmd_byte(id, k)));
        end
        get_char(b, ok);
        chk(ok && b == csum_of(id, n, enh, 1'b0), "R6 checksum char", int'(b),
            int'(csum_of(id, n, enh, 1'b0)));
      end
      begin : stray
        if (glitch) begin
          repeat (150) @(negedge clk);
          frame_id = 6'(id ^ 63); is_request = 1'b1; start = 1'b1; // R12
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    wait_done();
    chk(t_done - t_start == (14 + 10 * (3 + n)) * DIV + n + (stall_idx >= 0 ? stall : 0),
        stall_idx >= 0 ? "R5 stalled frame length" : "R4 frame length",
        t_done - t_start, (14 + 10 * (3 + n)) * DIV + n + (stall_idx >= 0 ? stall : 0));
    chk(err_code == 3'd0 && !err, "R13 command frame code", int'(err_code), 0);
    @(negedge clk);
    chk(!done && !busy && tx, "R13 done single cycle", int'(done), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop);
    slave_q = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      slave_q = b[i];
      repeat (DIV) @(negedge clk);
    end
    slave_q = stop;
    repeat (DIV) @(negedge clk);
    slave_q = 1'b1;
  endtask

  // mode: 0 good, 1 bad checksum, 2 short, 3 silent, 4 framing
  task automatic run_req(input int id, input int dlm1, input bit enh, input int mode);
    int n;
    int lows;
    int exp_code;
    int exp_n;
    n = dlm1 + 1;
    rcv_n = 0;
    lows = 0;
    send_start(id, 1'b1, dlm1, enh);
    check_header(id);
    fork
      begin : slave
        repeat (2 * DIV) @(negedge clk);
        if (mode == 4) send_byte(resp_byte(id, 0), 1'b0);
        else if (mode != 3) begin
          for (int k = 0; k < (mode == 2 ? n - 1 : n); k++) send_byte(resp_byte(id, k), 1'b1);
          if (mode != 2)
            send_byte(csum_of(id, n, enh, 1'b1) ^ (mode == 1 ? 8'h01 : 8'h00), 1'b1);
        end
      end
      begin : watch
        int k;
        k = 0;
        while (!done && k < 20000) begin
          if (!tx) lows++;
          @(negedge clk);
          k++;
        end
        t_done = cyc;
      end
    join
    exp_code = (mode == 0) ? 0 : (mode == 1) ? 3 : (mode == 4) ? 4 : 2;
    exp_n = (mode <= 1) ? n : (mode == 2) ? n - 1 : 0;
    chk(lows == 0, "R7 bus released", lows, 0);
    chk(rcv_n == exp_n, "R7 bytes forwarded", rcv_n, exp_n);
    for (int k = 0; k < exp_n && k < 16; k++)
      chk(rcv[k] == resp_byte(id, k), "R7 received byte", int'(rcv[k]), int'(resp_byte(id, k)));
    chk(int'(err_code) == exp_code,
        mode == 1 ? "R8 checksum error" : mode == 4 ? "R11 framing error" :
        mode >= 2 ? "R10 timeout error" : "R6 received checksum ok",
        int'(err_code), exp_code);
    chk(err == (exp_code != 0), "R13 err flag", int'(err), int'(exp_code != 0));
    if (mode == 3)
      chk(t_done - t_start == (34 + TMO) * DIV, "R10 silent timeout length",
          t_done - t_start, (34 + TMO) * DIV);
    repeat (3 * DIV) @(negedge clk);
    chk(int'(err_code) == exp_code && !busy, "R13 code held", int'(err_code), exp_code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx && !busy && !done && !wr_ready && !rd_valid, "R1 reset state", int'(tx), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx && !busy && !done && !wr_ready && !rd_valid && err_code == 3'd0,
        "R1 idle after reset", int'(busy), 0);

    for (int id = 0; id < 64; id++) begin
      run_cmd(id, id % 8, id[0], -1, 0, id == 5);
      repeat (5) @(negedge clk);
    end
    run_cmd(9, 3, 1'b1, 2, 25, 1'b0);
    run_cmd(22, 0, 1'b0, 0, 7, 1'b0);

    for (int d = 0; d < 8; d++) run_req(3 + 7 * d, d, d[0], 0);
    run_req(17, 4, 1'b1, 1);
    run_req(40, 0, 1'b0, 1);
    run_req(12, 5, 1'b0, 2);
    run_req(33, 0, 1'b1, 2);
    run_req(50, 7, 1'b1, 3);
    run_req(8, 2, 1'b0, 4);

    // R9: line held low after the break
    wr_valid = 1'b1; wr_data = 8'hA5;
    send_start(19, 1'b0, 2, 1'b0);
    while (!tx) @(negedge clk);
    stuck = 1'b1;
    wait_done();
    chk(err_code == 3'd1 && err, "R9 bit error code", int'(err_code), 1);
    @(negedge clk);
    chk(tx && !busy, "R9 line released after abort", int'(tx), 1);
    stuck = 1'b0;
    wr_valid = 1'b0;
    repeat (5) @(negedge clk);
    run_req(27, 1, 1'b0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule